// File: doc/BRIEF.md
# Dual 8-bit Timer with Pulse and PWM Generation

This block pairs two 8-bit up-counters that share one flip-flop output. A 2-bit mode input picks one of four arrangements. In the first, the counters run as two separate interval timers. In the second, they chain into one 16-bit timer. In the third, the lower counter drives a programmable pulse generator whose period and high time are set independently. In the fourth, the lower counter drives a PWM channel with a period of 2^6, 2^7 or 2^8 counts, while the upper counter runs on as a plain timer.

Counting is clocked by ticks taken either from a free-running internal prescaler or from an external count strobe. The prescaler taps run at ratios of 1, 4, 16 and 256 relative to its base tick.

The two compare values are loaded through a plain write port into staging registers. They reach the counters only at a period boundary, or while the block is stopped. No data streams pass through the block. Every pin is a control or status level or a one-clock pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_timer_pwm`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, tff_out, match_lo, match_hi and pwm_wrap are all 0. The prescaler restarts from zero at reset.
- R2: The internal prescaler advances once per clock. With STEP_LOG=1, tap T1 fires every 2 clocks, T4 every 8, T16 every 32 and T256 every 512. The lower clock select lo_src picks the lower counter's tick: 00 is ext_cnt (sampled high on a clock edge), 01 is T1, 10 is T4 and 11 is T16.
- R3: In split mode the upper clock select hi_src picks the upper counter's tick: 00 is a lower-counter match, 01 is T1, 10 is T16 and 11 is T256. In PWM mode, code 00 stops the upper counter.
- R4: In split mode (mode 00), each counter counts up on its ticks. A tick taken while the counter equals its compare value clears it to 0. One clock after that tick, the counter's match output (match_lo or match_hi) pulses for exactly one cycle, so the period is compare+1 ticks.
- R5: In split mode, ff_src=0 toggles tff_out on every lower match and ff_src=1 toggles it on every upper match. The change appears in the same cycle as the match pulse.
- R6: In 16-bit mode (mode 01), the counters form one 16-bit value counted by the lower tick, with the lower byte's carry advancing the upper byte. A tick at {upper compare, lower compare} clears both bytes, pulses match_hi and toggles tff_out. hi_src and ff_src have no effect.
- R7: In PPG mode (mode 10), a tick while the lower counter equals the upper compare clears the counter, drives tff_out low and pulses match_hi. Otherwise, a tick while the counter equals the lower compare drives tff_out high and pulses match_lo. The upper compare wins when the two are equal.
- R8: In PWM mode (mode 11), the lower counter wraps modulo 2^6, 2^7 or 2^8 counts for pwm_len 01, 10 or 11 (00 acts as 11). The wrapping tick pulses pwm_wrap one clock later.
- R9: In PWM mode, tff_out goes high at each wrap and low when the counter steps onto the lower compare value C. The output is therefore high for C counts of each period. C=0 gives a constant low and C at or above the period gives a constant high. Upper-counter matches still pulse match_hi but never touch tff_out.
- R10: A compare write lands in a staging register. The working compare takes the staged value only at that counter's period boundary (its match tick; the 16-bit or PPG period end for both; the wrap for the lower counter in PWM mode), or on any clock while run_en is low.
- R11: While run_en is low, both counters are held at 0, no match or wrap pulse is raised, and tff_out keeps its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable; low holds counters at zero |
| mode | input | 2 | 00 split, 01 cascaded 16-bit, 10 PPG, 11 PWM |
| lo_src | input | 2 | Lower counter tick source |
| hi_src | input | 2 | Upper counter tick source |
| pwm_len | input | 2 | PWM period select |
| ff_src | input | 1 | Split mode: 0 lower match, 1 upper match toggles the flip-flop |
| ext_cnt | input | 1 | External count strobe, one count per clock it is high |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | 0 writes the lower compare, 1 the upper compare |
| wr_data | input | 8 | Compare value to stage |
| tff_out | output | 1 | Timer flip-flop output |
| match_lo | output | 1 | One-cycle lower compare match pulse |
| match_hi | output | 1 | One-cycle upper / 16-bit / PPG period match pulse |
| pwm_wrap | output | 1 | One-cycle PWM period wrap pulse |

## Verification
The bench goes after the edges of the compare logic. One target is the PWM duty at 0 and at a value beyond the period: a design that compared the full 8-bit counter, or set the output on the wrap regardless of the compare, would glitch high or fall low where it should stay flat. Another is PPG with the two compares ordered both ways: a wrong priority would leave the output stuck high. A third is the 16-bit carry across the lower byte: a design that matched the bytes separately would fire 256 times too often. Compare writes made in mid-period are checked too; a design without staging shows a short or long period at once. Stopping the block while the output is high is exercised, where a design that cleared the flip-flop would drop it.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_CASC  = 2'b01,
    MODE_PPG   = 2'b10,
    MODE_PWM   = 2'b11
  } dtp_mode_e;

  // indices into the prescaler tap vector
  localparam int TAP_X1   = 0;
  localparam int TAP_X4   = 1;
  localparam int TAP_X16  = 2;
  localparam int TAP_X256 = 3;
  localparam int NUM_TAPS = 4;
endpackage

// File: rtl/dtp_prescaler.sv
module dtp_prescaler #(
  parameter int STEP_LOG = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [dtp_pkg::NUM_TAPS-1:0] taps
);
  localparam int PRE_W = STEP_LOG + 8;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // tap g fires when its low LEN bits are all ones
  for (genvar g = 0; g < dtp_pkg::NUM_TAPS; g++) begin : g_tap
    localparam int LEN = STEP_LOG + ((g == dtp_pkg::TAP_X256) ? 8 : 2 * g);
    assign taps[g] = &pre_q[LEN-1:0];
  end
endmodule

// File: rtl/dtp_cmp_buf.sv
module dtp_cmp_buf #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             load,
  output logic [CNT_W-1:0] staged,
  output logic [CNT_W-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      active <= '0;
    end else begin
      if (wr)   staged <= wdata;
      if (load) active <= staged;
    end
  end
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm #(
  parameter int CNT_W    = 8,
  parameter int STEP_LOG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       mode,
  input  logic [1:0]       lo_src,
  input  logic [1:0]       hi_src,
  input  logic [1:0]       pwm_len,
  input  logic             ff_src,
  input  logic             ext_cnt,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             tff_out,
  output logic             match_lo,
  output logic             match_hi,
  output logic             pwm_wrap
);
  import dtp_pkg::*;

  localparam int NCH = 2;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  dtp_mode_e mode_e;
  assign mode_e = dtp_mode_e'(mode);

  logic [NUM_TAPS-1:0] taps;

  dtp_prescaler #(.STEP_LOG(STEP_LOG)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (taps)
  );

  // compare staging: channel 0 lower, channel 1 upper
  logic [NCH-1:0]            ld;
  logic [NCH-1:0][CNT_W-1:0] cmp_stg;
  logic [NCH-1:0][CNT_W-1:0] cmp_act;

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    dtp_cmp_buf #(.CNT_W(CNT_W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_en && (wr_sel == c[0])),
      .wdata  (wr_data),
      .load   (ld[c]),
      .staged (cmp_stg[c]),
      .active (cmp_act[c])
    );
  end

  logic [CNT_W-1:0] lo_cnt, hi_cnt, lo_nxt, hi_nxt;
  logic             tff_q, tff_nxt;
  logic             mlo_q, mhi_q, wrap_q;
  logic             mlo_nxt, mhi_nxt, wrap_nxt;
  logic             lo_tick, hi_tap, hi_tick;
  logic             lo_eq, hi_eq;
  logic [CNT_W-1:0] pwm_top;

  always_comb begin
    unique case (lo_src)
      2'b00:   lo_tick = ext_cnt;
      2'b01:   lo_tick = taps[TAP_X1];
      2'b10:   lo_tick = taps[TAP_X4];
      default: lo_tick = taps[TAP_X16];
    endcase
    unique case (hi_src)
      2'b01:   hi_tap = taps[TAP_X1];
      2'b10:   hi_tap = taps[TAP_X16];
      2'b11:   hi_tap = taps[TAP_X256];
      default: hi_tap = 1'b0;
    endcase
    unique case (pwm_len)
      2'b01:   pwm_top = FULL >> 2;
      2'b10:   pwm_top = FULL >> 1;
      default: pwm_top = FULL;
    endcase
  end

  assign lo_eq = (lo_cnt == cmp_act[0]);
  assign hi_eq = (hi_cnt == cmp_act[1]);

  always_comb begin
    lo_nxt   = lo_cnt;
    hi_nxt   = hi_cnt;
    tff_nxt  = tff_q;
    mlo_nxt  = 1'b0;
    mhi_nxt  = 1'b0;
    wrap_nxt = 1'b0;
    ld       = {NCH{!run_en}};
    hi_tick  = 1'b0;
    if (!run_en) begin
      lo_nxt = '0;
      hi_nxt = '0;
    end else begin
      unique case (mode_e)
        MODE_SPLIT: begin
          hi_tick = (hi_src == 2'b00) ? (lo_tick && lo_eq) : hi_tap;
          if (lo_tick) begin
            if (lo_eq) begin
              lo_nxt  = '0;
              mlo_nxt = 1'b1;
              ld[0]   = 1'b1;
            end else lo_nxt = lo_cnt + ONE;
          end
          if (hi_tick) begin
            if (hi_eq) begin
              hi_nxt  = '0;
              mhi_nxt = 1'b1;
              ld[1]   = 1'b1;
            end else hi_nxt = hi_cnt + ONE;
          end
          if (ff_src ? mhi_nxt : mlo_nxt) tff_nxt = ~tff_q;
        end
        MODE_CASC: begin
          if (lo_tick) begin
            if (lo_eq && hi_eq) begin
              lo_nxt  = '0;
              hi_nxt  = '0;
              mhi_nxt = 1'b1;
              ld      = {NCH{1'b1}};
              tff_nxt = ~tff_q;
            end else {hi_nxt, lo_nxt} = {hi_cnt, lo_cnt} + {{CNT_W{1'b0}}, ONE};
          end
        end
        MODE_PPG: begin
          hi_nxt = '0;
          if (lo_tick) begin
            if (lo_cnt == cmp_act[1]) begin
              lo_nxt  = '0;
              tff_nxt = 1'b0;
              mhi_nxt = 1'b1;
              ld      = {NCH{1'b1}};
            end else begin
              lo_nxt = lo_cnt + ONE;
              if (lo_eq) begin
                tff_nxt = 1'b1;
                mlo_nxt = 1'b1;
              end
            end
          end
        end
        default: begin // MODE_PWM
          if (lo_tick) begin
            if (lo_cnt == pwm_top) begin
              lo_nxt   = '0;
              wrap_nxt = 1'b1;
              ld[0]    = 1'b1;
              tff_nxt  = (cmp_stg[0] != '0);
            end else begin
              lo_nxt = lo_cnt + ONE;
              if ((lo_cnt + ONE) == cmp_act[0]) begin
                tff_nxt = 1'b0;
                mlo_nxt = 1'b1;
              end
            end
          end
          hi_tick = hi_tap;
          if (hi_tick) begin
            if (hi_eq) begin
              hi_nxt  = '0;
              mhi_nxt = 1'b1;
              ld[1]   = 1'b1;
            end else hi_nxt = hi_cnt + ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      tff_q  <= 1'b0;
      mlo_q  <= 1'b0;
      mhi_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      lo_cnt <= lo_nxt;
      hi_cnt <= hi_nxt;
      tff_q  <= tff_nxt;
      mlo_q  <= mlo_nxt;
      mhi_q  <= mhi_nxt;
      wrap_q <= wrap_nxt;
    end
  end

  assign tff_out  = tff_q;
  assign match_lo = mlo_q;
  assign match_hi = mhi_q;
  assign pwm_wrap = wrap_q;

  // R11
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!mlo_q && !mhi_q && !wrap_q));

  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(tff_q));

  // R9
  pwm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mlo_q && wrap_q));

  // R7
  ppg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_e == MODE_PPG) && $rose(tff_q)) |-> mlo_q);

  // R8
  wrap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> ($past(mode) == 2'b11));
endmodule

// File: tb/dual_timer_pwm_tb.sv
module dual_timer_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 60000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [1:0] mode = 2'b00, lo_src = 2'b01, hi_src = 2'b00, pwm_len = 2'b11;
  logic       ff_src = 1'b0, ext_cnt = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       tff_out, match_lo, match_hi, pwm_wrap;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
    .lo_src(lo_src), .hi_src(hi_src), .pwm_len(pwm_len), .ff_src(ff_src),
    .ext_cnt(ext_cnt), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tff_out(tff_out), .match_lo(match_lo), .match_hi(match_hi),
    .pwm_wrap(pwm_wrap)
  );

  // behavioural reference state
  int  m_pre = 0, m_lo = 0, m_hi = 0, m_la = 0, m_ha = 0, m_lb = 0, m_hb = 0;
  bit  e_tff = 0, e_mlo = 0, e_mhi = 0, e_wrap = 0;
  bit  started = 0, done = 0;
  int  n_cmp = 0, n_bad = 0, cycles = 0;
  string phase = "R1";

  function automatic bit tap(int per);
    return (m_pre % per) == per - 1;
  endfunction

  always @(posedge clk) begin
    int  nlb, nhb, top;
    bit  lt, ht, lh, hh, t1, t4, t16, t256;
    started = 1;
    cycles++;
    if (!rst_n) begin
      m_pre = 0; m_lo = 0; m_hi = 0; m_la = 0; m_ha = 0; m_lb = 0; m_hb = 0;
      e_tff = 0; e_mlo = 0; e_mhi = 0; e_wrap = 0;
    end else begin
      t1 = tap(2); t4 = tap(8); t16 = tap(32); t256 = tap(512);
      m_pre = (m_pre + 1) % 512;
      nlb = m_lb; nhb = m_hb;
      if (wr_en) begin
        if (wr_sel) nhb = int'(wr_data); else nlb = int'(wr_data);
      end
      e_mlo = 0; e_mhi = 0; e_wrap = 0;
      lt = (lo_src == 0) ? ext_cnt : (lo_src == 1) ? t1 : (lo_src == 2) ? t4 : t16;
      if (!run_en) begin
        m_lo = 0; m_hi = 0; m_la = m_lb; m_ha = m_hb;
      end else if (mode == 2'b00) begin
        lh = lt && (m_lo == m_la);
        ht = (hi_src == 0) ? lh : (hi_src == 1) ? t1 : (hi_src == 2) ? t16 : t256;
        hh = ht && (m_hi == m_ha);
        if (lt) m_lo = lh ? 0 : (m_lo + 1) % 256;
        if (ht) m_hi = hh ? 0 : (m_hi + 1) % 256;
        if (lh) begin e_mlo = 1; m_la = m_lb; end
        if (hh) begin e_mhi = 1; m_ha = m_hb; end
        if (ff_src ? hh : lh) e_tff = !e_tff;
      end else if (mode == 2'b01) begin
        if (lt) begin
          if (m_lo == m_la && m_hi == m_ha) begin
            m_lo = 0; m_hi = 0; e_mhi = 1; m_la = m_lb; m_ha = m_hb; e_tff = !e_tff;
          end else begin
            m_lo = (m_lo + 1) % 256;
            if (m_lo == 0) m_hi = (m_hi + 1) % 256;
          end
        end
      end else if (mode == 2'b10) begin
        m_hi = 0;
        if (lt) begin
          if (m_lo == m_ha) begin
            m_lo = 0; e_tff = 0; e_mhi = 1; m_la = m_lb; m_ha = m_hb;
          end else begin
            if (m_lo == m_la) begin e_tff = 1; e_mlo = 1; end
            m_lo = (m_lo + 1) % 256;
          end
        end
      end else begin
        top = (pwm_len == 1) ? 63 : (pwm_len == 2) ? 127 : 255;
        if (lt) begin
          if (m_lo == top) begin
            m_lo = 0; e_wrap = 1; m_la = m_lb; e_tff = (m_la != 0);
          end else begin
            m_lo++;
            if (m_lo == m_la) begin e_tff = 0; e_mlo = 1; end
          end
        end
        ht = (hi_src == 0) ? 0 : (hi_src == 1) ? t1 : (hi_src == 2) ? t16 : t256;
        hh = ht && (m_hi == m_ha);
        if (ht) m_hi = hh ? 0 : (m_hi + 1) % 256;
        if (hh) begin e_mhi = 1; m_ha = m_hb; end
      end
      m_lb = nlb; m_hb = nhb;
    end
  end

  task automatic chk(string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", phase, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("tff_out", tff_out, e_tff);
      chk("match_lo", match_lo, e_mlo);
      chk("match_hi", match_hi, e_mhi);
      chk("pwm_wrap", pwm_wrap, e_wrap);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, int v);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = 8'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  // stop, reconfigure, stage both compares, let them settle, restart
  task automatic setup(string tag, logic [1:0] md, logic [1:0] ls, logic [1:0] hs,
                       logic [1:0] pl, bit fs, int clo, int chi);
    @(negedge clk);
    run_en = 0; phase = tag;
    mode = md; lo_src = ls; hi_src = hs; pwm_len = pl; ff_src = fs;
    wr(0, clo);
    wr(1, chi);
    wait_cyc(2);
    run_en = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    phase = "R1";
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(4);
    // lower and upper match chain, flip-flop on lower match
    setup("R4", 2'b00, 2'b01, 2'b00, 2'b11, 1'b0, 3, 2);
    wait_cyc(200);
    // external strobe counts the lower counter
    setup("R2", 2'b00, 2'b00, 2'b00, 2'b11, 1'b0, 2, 1);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      ext_cnt = (k % 3 == 0);
    end
    ext_cnt = 0;
    setup("R2", 2'b00, 2'b10, 2'b01, 2'b11, 1'b1, 4, 6);
    wait_cyc(400);
    setup("R3", 2'b00, 2'b11, 2'b10, 2'b11, 1'b1, 1, 3);
    wait_cyc(500);
    setup("R5", 2'b00, 2'b01, 2'b11, 2'b11, 1'b1, 0, 1);
    wait_cyc(1100);
    // chained 16-bit count across the lower byte carry
    setup("R6", 2'b01, 2'b01, 2'b10, 2'b11, 1'b1, 5, 1);
    wait_cyc(1200);
    // pulse generator, both compare orders
    setup("R7", 2'b10, 2'b01, 2'b00, 2'b11, 1'b0, 3, 9);
    wait_cyc(200);
    setup("R7", 2'b10, 2'b01, 2'b00, 2'b11, 1'b0, 9, 3);
    wait_cyc(100);
    setup("R7", 2'b10, 2'b01, 2'b00, 2'b11, 1'b0, 4, 4);
    wait_cyc(100);
    // PWM period lengths with the upper timer running alongside
    setup("R8", 2'b11, 2'b01, 2'b01, 2'b01, 1'b0, 20, 5);
    wait_cyc(400);
    setup("R8", 2'b11, 2'b01, 2'b10, 2'b10, 1'b0, 20, 2);
    wait_cyc(600);
    setup("R8", 2'b11, 2'b01, 2'b01, 2'b11, 1'b0, 20, 7);
    wait_cyc(1100);
    setup("R8", 2'b11, 2'b01, 2'b00, 2'b00, 1'b0, 30, 7);
    wait_cyc(1100);
    // duty extremes
    setup("R9", 2'b11, 2'b01, 2'b01, 2'b01, 1'b0, 0, 3);
    wait_cyc(300);
    setup("R9", 2'b11, 2'b01, 2'b01, 2'b01, 1'b0, 100, 3);
    wait_cyc(300);
    setup("R9", 2'b11, 2'b01, 2'b01, 2'b01, 1'b0, 1, 3);
    wait_cyc(300);
    // mid-period compare writes
    setup("R10", 2'b11, 2'b01, 2'b01, 2'b01, 1'b0, 40, 9);
    wait_cyc(150);
    wr(0, 10);
    wait_cyc(30);
    wr(0, 50);
    wait_cyc(300);
    setup("R10", 2'b00, 2'b01, 2'b01, 2'b11, 1'b0, 30, 20);
    wait_cyc(20);
    wr(0, 2);
    wr(1, 1);
    wait_cyc(200);
    // stop while output is high, then resume
    setup("R11", 2'b11, 2'b01, 2'b01, 2'b01, 1'b0, 40, 5);
    wait_cyc(140);
    @(negedge clk);
    run_en = 0;
    wait_cyc(50);
    @(negedge clk);
    run_en = 1;
    wait_cyc(300);
    @(negedge clk);
    run_en = 0;
    wait_cyc(20);
    finish_run();
  end
endmodule